// File: doc/BRIEF.md
# Parallax Barrier Mask Sequencer

This block produces the drive word for a parallax barrier shutter and sends it, on every refresh tick, as two byte writes to the output-port registers of an I/O expander. Each word holds a mask in which each bit makes one barrier unit opaque (1) or transparent (0), plus one polarity bit. The mask comes from one of three sources. In tracking stereo mode it is a six-unit slit that rotates with the viewer's head position. In fixed stereo mode it is a constant five-unit slit. In flat (2D) mode it is all zeros. A host override word can replace the generated word.

The barrier must never see a DC level. For this reason the block keeps a phase bit and sends the true word and its complete bitwise inverse (polarity bit included) on alternating refreshes, in every mode. The serial bus master is not part of this block. The block presents a device address, a register index and a data byte on a request/acknowledge write port, and it moves to the next byte only when the master acknowledges.

Top module: `pbar_seq`

## Requirements
- R1: With `mode_i`=2'b01 (tracking), position p gives the 12-bit mask 12'b000011111100 rotated right by p places (bit 11 is the leftmost unit). The generated polarity bit 12 is 0.
- R2: With `mode_i`=2'b10 (fixed stereo), the mask is 12'b111100000111 and the polarity bit is 0, whatever the position.
- R3: With `mode_i` equal to 2'b00 or 2'b11 (flat), the generated word is all zeros.
- R4: A position above 11 is treated as position 11.
- R5: The phase is 0 after reset. A refresh sent in phase 1 carries the selected word XOR 13'h1FFF, and the phase flips after each completed refresh, in all modes.
- R6: Each refresh makes two writes to device 8'h40. The first goes to register 8'h02 with word bits 7:0. The second goes to register 8'h03 with word bits 12:8 in data bits 4:0 and zeros in data bits 7:5.
- R7: While `ovr_valid` is high at the start of a refresh, `ovr_word` replaces the generated word, and the phase inversion is still applied to it.
- R8: While `dis_i` is high at the start of a refresh, the word is all zeros, even if an override is valid. The phase inversion is still applied.
- R9: `wr_req` stays high and `wr_reg`/`wr_data` stay stable until `wr_ack`. After the second acknowledge `wr_req` falls.
- R10: A tick that arrives while a refresh is in progress is dropped and is not queued. The phase changes only when the second write is acknowledged.
- R11: Mode, position, override and disable are sampled only in the cycle a refresh starts. Changes during a refresh do not alter its second byte.
- R12: After reset `wr_req` is low, and the first refresh in flat mode sends all-zero bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Refresh request pulse |
| dis_i | input | 1 | Force the flat (all-zero) word |
| mode_i | input | 2 | 00/11 flat, 01 tracking, 10 fixed stereo |
| pos_i | input | 4 | Head position index, clamped to 11 |
| ovr_valid | input | 1 | Host override word is valid |
| ovr_word | input | 13 | Host override word (bit 12 polarity) |
| wr_req | output | 1 | Byte write request to bus master |
| wr_dev | output | 8 | Device address, 8-bit write form |
| wr_reg | output | 8 | Expander register index |
| wr_data | output | 8 | Data byte |
| wr_ack | input | 1 | Bus master accepted the byte |

## Verification
The bench builds the block with its default parameters: 12 units, a 6-unit slit at offset 2, and a 4-bit position input. A 4-bit position can take values 12 to 15, so the clamp can be exercised directly. The default 13-bit word also leaves three pad bits in the high byte, so the zero padding can be observed. All twelve rotations can be stepped through in one pass, and acknowledge latencies of 1 to 4 cycles leave room to inject dropped ticks and input changes in the middle of a refresh.

// File: rtl/pbar_pkg.sv
package pbar_pkg;

  typedef enum logic [1:0] {
    MODE_FLAT     = 2'b00,
    MODE_TRACK    = 2'b01,
    MODE_FIXED    = 2'b10,
    MODE_FLAT_ALT = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LO   = 2'b01,
    ST_HI   = 2'b10
  } wr_st_e;

  // A unit is opaque when its index, shifted by position and offset, lands
  // inside the slit window of the circular barrier.
  function automatic logic slit_bit(int unsigned idx, int unsigned pos,
                                    int unsigned ofs, int unsigned slit,
                                    int unsigned units);
    return ((idx + pos + units - ofs) % units) < slit;
  endfunction

  function automatic logic [7:0] low_byte(logic [31:0] w);
    return w[7:0];
  endfunction

  function automatic logic [7:0] high_byte(logic [31:0] w);
    return w[15:8];
  endfunction

endpackage

// File: rtl/pbar_pattern.sv
module pbar_pattern
  import pbar_pkg::*;
#(
  parameter int UNITS = 12,
  parameter int SLIT_W = 6,
  parameter int SLIT_OFS = 2,
  parameter int POS_W = 4,
  parameter logic [UNITS-1:0] FIXED_MASK = 12'hF07
) (
  input  mode_e            mode_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             ovr_valid_i,
  input  logic [UNITS:0]   ovr_word_i,
  input  logic             dis_i,
  output logic [UNITS:0]   word_o
);

  localparam logic [POS_W-1:0] POS_MAX = POS_W'(UNITS - 1);

  logic [POS_W-1:0] pos_c;
  logic [UNITS-1:0] track_mask;
  logic [UNITS-1:0] mask_sel;

  assign pos_c = (pos_i > POS_MAX) ? POS_MAX : pos_i;

  for (genvar i = 0; i < UNITS; i++) begin : g_unit
    assign track_mask[i] = slit_bit(i, int'(pos_c), SLIT_OFS, SLIT_W, UNITS);
  end

  always_comb begin
    unique case (mode_i)
      MODE_TRACK: mask_sel = track_mask;
      MODE_FIXED: mask_sel = FIXED_MASK;
      default:    mask_sel = '0;
    endcase
  end

  always_comb begin
    if (dis_i)            word_o = '0;
    else if (ovr_valid_i) word_o = ovr_word_i;
    else                  word_o = {1'b0, mask_sel};
  end

endmodule

// File: rtl/pbar_wr_fsm.sv
module pbar_wr_fsm
  import pbar_pkg::*;
#(
  parameter int WORD_W = 13,
  parameter logic [7:0] DEV_ADDR = 8'h40,
  parameter logic [7:0] REG_LO = 8'h02,
  parameter logic [7:0] REG_HI = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              wr_ack_i,
  output logic              wr_req_o,
  output logic [7:0]        wr_dev_o,
  output logic [7:0]        wr_reg_o,
  output logic [7:0]        wr_data_o,
  output logic              phase_o,
  output logic              start_o,
  output logic              done_o,
  output logic              drop_o
);

  wr_st_e            st_q;
  logic              phase_q;
  logic [WORD_W-1:0] word_q;
  logic [31:0]       word_ext;

  assign start_o = tick_i && (st_q == ST_IDLE);
  assign drop_o  = tick_i && (st_q != ST_IDLE);
  assign done_o  = (st_q == ST_HI) && wr_ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      phase_q <= 1'b0;
      word_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_o) begin
          word_q <= word_i ^ {WORD_W{phase_q}};
          st_q   <= ST_LO;
        end
        ST_LO: if (wr_ack_i) st_q <= ST_HI;
        ST_HI: if (wr_ack_i) begin
          st_q    <= ST_IDLE;
          phase_q <= ~phase_q;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign word_ext  = 32'(word_q);
  assign phase_o   = phase_q;
  assign wr_req_o  = (st_q != ST_IDLE);
  assign wr_dev_o  = DEV_ADDR;
  assign wr_reg_o  = (st_q == ST_HI) ? REG_HI : REG_LO;
  assign wr_data_o = (st_q == ST_HI) ? high_byte(word_ext) : low_byte(word_ext);

endmodule

// File: rtl/pbar_seq.sv
module pbar_seq
  import pbar_pkg::*;
#(
  parameter int UNITS = 12,
  parameter int SLIT_W = 6,
  parameter int SLIT_OFS = 2,
  parameter int POS_W = 4,
  parameter logic [UNITS-1:0] FIXED_MASK = 12'hF07,
  parameter logic [7:0] DEV_ADDR = 8'h40,
  parameter logic [7:0] REG_LO = 8'h02,
  parameter logic [7:0] REG_HI = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dis_i,
  input  logic [1:0]       mode_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             ovr_valid,
  input  logic [UNITS:0]   ovr_word,
  output logic             wr_req,
  output logic [7:0]       wr_dev,
  output logic [7:0]       wr_reg,
  output logic [7:0]       wr_data,
  input  logic             wr_ack
);

  localparam int WORD_W = UNITS + 1;

  logic [WORD_W-1:0] word_sel;
  logic              phase_q;
  logic              start_evt;
  logic              done_evt;
  logic              drop_evt;

  pbar_pattern #(
    .UNITS(UNITS), .SLIT_W(SLIT_W), .SLIT_OFS(SLIT_OFS),
    .POS_W(POS_W), .FIXED_MASK(FIXED_MASK)
  ) u_pat (
    .mode_i(mode_e'(mode_i)),
    .pos_i(pos_i),
    .ovr_valid_i(ovr_valid),
    .ovr_word_i(ovr_word),
    .dis_i(dis_i),
    .word_o(word_sel)
  );

  pbar_wr_fsm #(
    .WORD_W(WORD_W), .DEV_ADDR(DEV_ADDR),
    .REG_LO(REG_LO), .REG_HI(REG_HI)
  ) u_fsm (
    .clk(clk),
    .rst_n(rst_n),
    .tick_i(tick),
    .word_i(word_sel),
    .wr_ack_i(wr_ack),
    .wr_req_o(wr_req),
    .wr_dev_o(wr_dev),
    .wr_reg_o(wr_reg),
    .wr_data_o(wr_data),
    .phase_o(phase_q),
    .start_o(start_evt),
    .done_o(done_evt),
    .drop_o(drop_evt)
  );

endmodule

// File: rtl/pbar_seq_chk.sv
module pbar_seq_chk #(
  parameter int UNITS = 12,
  parameter logic [7:0] DEV_ADDR = 8'h40,
  parameter logic [7:0] REG_LO = 8'h02,
  parameter logic [7:0] REG_HI = 8'h03
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_req,
  input logic       wr_ack,
  input logic [7:0] wr_dev,
  input logic [7:0] wr_reg,
  input logic [7:0] wr_data,
  input logic       phase_q,
  input logic       start_evt,
  input logic       done_evt,
  input logic       drop_evt
);

  localparam int PAD_SH = UNITS + 1 - 8;

  // R6
  dev_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_dev == DEV_ADDR);

  // R6
  lo_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> wr_req && wr_reg == REG_LO);

  // R6
  hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_reg == REG_HI) |-> (wr_data >> PAD_SH) == 8'd0);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req && $stable(wr_reg) && $stable(wr_data));

  // R10
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> phase_q != $past(phase_q));

  // R10
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(phase_q));

  // R10
  drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> wr_req && !start_evt);

endmodule

bind pbar_seq pbar_seq_chk #(
  .UNITS(UNITS), .DEV_ADDR(DEV_ADDR), .REG_LO(REG_LO), .REG_HI(REG_HI)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .wr_req(wr_req),
  .wr_ack(wr_ack),
  .wr_dev(wr_dev),
  .wr_reg(wr_reg),
  .wr_data(wr_data),
  .phase_q(phase_q),
  .start_evt(start_evt),
  .done_evt(done_evt),
  .drop_evt(drop_evt)
);

// File: tb/pbar_seq_test.sv
`timescale 1ns/1ps
module pbar_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        dis_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [3:0]  pos_i = 4'd0;
  logic        ovr_valid = 1'b0;
  logic [12:0] ovr_word = 13'd0;
  logic        wr_req;
  logic [7:0]  wr_dev, wr_reg, wr_data;
  logic        wr_ack = 1'b0;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  ph = 1'b0;
  bit  ended = 1'b0;

  always #4 clk = ~clk;

  pbar_seq uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dis_i(dis_i), .mode_i(mode_i),
    .pos_i(pos_i), .ovr_valid(ovr_valid), .ovr_word(ovr_word),
    .wr_req(wr_req), .wr_dev(wr_dev), .wr_reg(wr_reg), .wr_data(wr_data),
    .wr_ack(wr_ack)
  );

  function automatic logic [11:0] ref_track(int p);
    logic [23:0] twice;
    if (p > 11) p = 11;
    twice = {12'h0FC, 12'h0FC};
    return 12'(twice >> p);
  endfunction

  function automatic logic [12:0] ref_word();
    if (dis_i) return 13'd0;
    if (ovr_valid) return ovr_word;
    case (mode_i)
      2'b01:   return {1'b0, ref_track(int'(pos_i))};
      2'b10:   return 13'b0_1111_0000_0111;
      default: return 13'd0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic ack_pulse();
    wr_ack = 1'b1;
    @(negedge clk);
    wr_ack = 1'b0;
  endtask

  // One full refresh; lat cycles before each acknowledge.
  task automatic refresh(int lat, bit wig, bit extra, string tag);
    logic [12:0] e;
    e = ref_word() ^ (ph ? 13'h1FFF : 13'h0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(wr_req && wr_reg == 8'h02 && wr_dev == 8'h40, "R6", int'(wr_reg), 2);
    chk(wr_data == e[7:0], tag, int'(wr_data), int'(e[7:0]));
    for (int k = 0; k < lat; k++) begin
      if (wig && k == 0) begin
        mode_i = 2'($urandom);
        pos_i = 4'($urandom);
        ovr_valid = 1'($urandom);
        ovr_word = 13'($urandom);
        dis_i = 1'($urandom_range(0, 3) == 0);
      end
      if (extra && k == 0) tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      chk(wr_req && wr_reg == 8'h02, "R9", int'(wr_reg), 2);
    end
    ack_pulse();
    chk(wr_req && wr_reg == 8'h03, "R6", int'(wr_reg), 3);
    chk(wr_data == {3'b000, e[12:8]}, wig ? "R11" : tag, int'(wr_data),
        int'({3'b000, e[12:8]}));
    repeat (lat) @(negedge clk);
    ack_pulse();
    chk(!wr_req, "R9", int'(wr_req), 0);
    if (extra) begin
      @(negedge clk);
      chk(!wr_req, "R10", int'(wr_req), 0);
    end
    ph = ~ph;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_req, "R12", int'(wr_req), 0);
    refresh(1, 0, 0, "R12");
    refresh(2, 0, 0, "R3");            // phase 1: flat sends 1FFF (R5)
    mode_i = 2'b11;
    refresh(1, 0, 0, "R3");
    mode_i = 2'b01;
    for (int p = 0; p < 12; p++) begin
      pos_i = 4'(p);
      refresh(1, 0, 0, "R1");
    end
    for (int p = 12; p < 16; p++) begin
      pos_i = 4'(p);
      refresh(1, 0, 0, "R4");
    end
    mode_i = 2'b10;
    pos_i = 4'd0;
    refresh(1, 0, 0, "R2");
    pos_i = 4'd7;
    refresh(2, 0, 0, "R2");
    pos_i = 4'd3;
    refresh(1, 0, 0, "R2");
    mode_i = 2'b01;
    ovr_valid = 1'b1;
    ovr_word = 13'h1A5C;
    refresh(1, 0, 0, "R7");
    refresh(3, 0, 0, "R7");
    dis_i = 1'b1;
    refresh(1, 0, 0, "R8");
    refresh(1, 0, 0, "R8");
    dis_i = 1'b0;
    ovr_valid = 1'b0;
    refresh(3, 0, 1, "R10");
    refresh(2, 1, 0, "R11");
    for (int n = 0; n < 150; n++) begin
      mode_i = 2'($urandom);
      pos_i = 4'($urandom);
      ovr_valid = 1'($urandom_range(0, 4) == 0);
      ovr_word = 13'($urandom);
      dis_i = 1'($urandom_range(0, 7) == 0);
      refresh(int'($urandom_range(1, 4)), 1'($urandom), 1'($urandom), "R5");
    end
    finish_run();
  end

endmodule